// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block runs on the host side of an external parallel flash. After the host has started a program or erase in the flash, it pulses `start` with an address inside the sector being worked on. The controller then reads that address repeatedly over a single-outstanding request/acknowledge bus. It reads in pairs and compares the busy-toggle bit across the two reads of each pair. This tells it whether the embedded operation in the flash is still running.

When the toggle bit stops changing, one further read fetches the real array contents. The controller shows that byte on `result_data` with a pass flag. If the error bit shows up while the flash still toggles, the controller allows one confirming pair. If toggling persists through that pair, it declares failure and writes the reset command to put the flash back in array-read mode. A watchdog limits how many read pairs the controller will spend.

The polling address must fall inside the sector being modified and must not lie in a protected sector. Otherwise the toggle bit carries no meaning. Meeting that condition is the caller's responsibility.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `pass` and `bus_req` are 0.
- R2: Each poll consists of two reads (`bus_we`=0) at the address captured at `start`. A raised `bus_req` keeps `bus_addr`, `bus_we` and `bus_wdata` unchanged until `bus_ack` is seen, and only one transaction is open at a time.
- R3: If bit 6 of the two reads of a pair is equal, the controller makes exactly one more read at the same address. It then ends with `pass`=1 and `result_data` equal to the data of that last read.
- R4: If bit 6 differs and bit 5 of the second read is 0, and the watchdog has not run out, another pair of reads follows.
- R5: If bit 6 differs and bit 5 of the second read is 1, exactly one more pair follows. The outcome is pass (as in R3) if its bit 6 values match, and fail if they differ.
- R6: On fail, the controller makes exactly one write with `bus_wdata`=8'hF0 at the polling address. It then ends with `pass`=0 and `result_data`=0.
- R7: If a pair with differing bit 6 is pair number `max_pairs` or later (counting from 1), the result is fail (R6). A `max_pairs` of 0 behaves as 1.
- R8: `busy` rises in the cycle after an accepted `start` and stays high until the end. `done` is a single-cycle pulse, and `busy` is already low in that cycle.
- R9: A `start` pulse while `busy` is high is ignored: no transfer goes to its address and no second `done` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| poll_addr | input | ADDR_W | Address inside the sector under operation |
| max_pairs | input | WDOG_W | Read-pair budget for the watchdog |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | 1 = operation finished, 0 = failure |
| result_data | output | DATA_W | Array data read after a pass, 0 after a fail |
| bus_req | output | 1 | Transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Transaction completion, one cycle |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |

## Verification
The bench builds the block with ADDR_W=4, DATA_W=8 and WDOG_W=4, so that `max_pairs` values of 0, 1, 3 and 8 cover both an immediate watchdog abort and a budget longer than any busy period it models. A flash responder toggles bit 6 for a chosen number of reads, raises bit 5 from a chosen read onward, and acknowledges with latency of 0 to 2 cycles. Sweeping the busy length, the error onset, the budget and the final array byte reaches every path: a plain pass, a pass inside the confirming pair, a fail after confirmation, and a watchdog fail. The bench predicts the outcome, read count and write count arithmetically.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_RD_FIN,
    ST_WR_RST
  } fpc_state_t;
endpackage

// File: rtl/fpc_bus_port.sv
module fpc_bus_port #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              issue_we,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic [DATA_W-1:0] issue_wdata,
  output logic              xfer_done,
  output logic [DATA_W-1:0] xfer_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req    <= 1'b0;
      bus_we     <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      xfer_done  <= 1'b0;
      xfer_rdata <= '0;
    end else begin
      xfer_done <= 1'b0;
      if (bus_req) begin
        if (bus_ack) begin
          bus_req    <= 1'b0;
          xfer_done  <= 1'b1;
          xfer_rdata <= bus_rdata;
        end
      end else if (issue) begin
        bus_req   <= 1'b1;
        bus_we    <= issue_we;
        bus_addr  <= issue_addr;
        bus_wdata <= issue_wdata;
      end
    end
  end
endmodule

// File: rtl/fpc_pair_wdog.sv
module fpc_pair_wdog #(
  parameter int WDOG_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  input  logic [WDOG_W-1:0] limit,
  output logic              last_pair
);
  localparam logic [WDOG_W-1:0] CNT_MAX = {WDOG_W{1'b1}};

  logic [WDOG_W-1:0] pairs_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pairs_q <= '0;
    end else if (inc && pairs_q != CNT_MAX) begin
      pairs_q <= pairs_q + 1'b1;
    end
  end

  // the pair now finishing is number pairs_q+1
  assign last_pair = ({1'b0, pairs_q} + 1'b1) >= {1'b0, limit};
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl #(
  parameter int                ADDR_W    = 19,
  parameter int                DATA_W    = 8,
  parameter int                WDOG_W    = 16,
  parameter int                TOG_BIT   = 6,
  parameter int                ERR_BIT   = 5,
  parameter logic [DATA_W-1:0] RESET_CMD = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] poll_addr,
  input  logic [WDOG_W-1:0] max_pairs,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [DATA_W-1:0] result_data,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  import fpc_pkg::*;

  fpc_state_t        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] first_q;
  logic              confirm_q;
  logic              pending_q;
  logic              xfer_done;
  logic [DATA_W-1:0] xfer_rdata;
  logic              issue;
  logic              wd_clr;
  logic              wd_inc;
  logic              last_pair;
  logic              same_tog;

  assign issue    = (state_q != ST_IDLE) && !pending_q;
  assign same_tog = first_q[TOG_BIT] == xfer_rdata[TOG_BIT];
  assign wd_clr   = (state_q == ST_IDLE) && start;
  assign wd_inc   = (state_q == ST_RD_B) && xfer_done && !same_tog &&
                    !last_pair && !confirm_q;
  assign busy     = (state_q != ST_IDLE);

  fpc_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .issue_we   (state_q == ST_WR_RST),
    .issue_addr (addr_q),
    .issue_wdata(RESET_CMD),
    .xfer_done  (xfer_done),
    .xfer_rdata (xfer_rdata),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .bus_rdata  (bus_rdata)
  );

  fpc_pair_wdog #(.WDOG_W(WDOG_W)) u_wdog (
    .clk      (clk),
    .rst      (rst),
    .clr      (wd_clr),
    .inc      (wd_inc),
    .limit    (max_pairs),
    .last_pair(last_pair)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      first_q     <= '0;
      confirm_q   <= 1'b0;
      pending_q   <= 1'b0;
      done        <= 1'b0;
      pass        <= 1'b0;
      result_data <= '0;
    end else begin
      done <= 1'b0;
      if (issue) pending_q <= 1'b1;
      else if (xfer_done) pending_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            addr_q    <= poll_addr;
            confirm_q <= 1'b0;
            state_q   <= ST_RD_A;
          end
        end
        ST_RD_A: begin
          if (xfer_done) begin
            first_q <= xfer_rdata;
            state_q <= ST_RD_B;
          end
        end
        ST_RD_B: begin
          if (xfer_done) begin
            if (same_tog) begin
              state_q <= ST_RD_FIN;
            end else if (last_pair || confirm_q) begin
              state_q <= ST_WR_RST;
            end else begin
              confirm_q <= xfer_rdata[ERR_BIT];
              state_q   <= ST_RD_A;
            end
          end
        end
        ST_RD_FIN: begin
          if (xfer_done) begin
            result_data <= xfer_rdata;
            pass        <= 1'b1;
            done        <= 1'b1;
            state_q     <= ST_IDLE;
          end
        end
        ST_WR_RST: begin
          if (xfer_done) begin
            result_data <= '0;
            pass        <= 1'b0;
            done        <= 1'b1;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int                ADDR_W    = 19,
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] RESET_CMD = 8'hF0
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy); // R8

  AST_WRITE_CMD: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we |-> bus_wdata == RESET_CMD); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_req); // R9

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack |=> !bus_req); // R2
endmodule

bind flash_poll_ctrl fpc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_CMD(RESET_CMD)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/sim_flash_poll_ctrl.sv
`timescale 1ns/1ps
module sim_flash_poll_ctrl;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] poll_addr = '0;
  logic [WW-1:0] max_pairs = '0;
  logic          busy, done, pass;
  logic [DW-1:0] result_data;
  logic          bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_ack = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  int n_cmp = 0;
  int n_bad = 0;

  // flash model settings
  int            m_busy = 0;
  int            m_err  = 0;
  int            m_lat  = 0;
  logic [DW-1:0] m_arr  = '0;
  logic [AW-1:0] m_addr = '0;
  int rd_cnt = 0, wr_cnt = 0, bad_addr = 0, lat_cnt = 0, done_cnt = 0;
  logic [DW-1:0] wr_last = '0;

  always #2 clk = ~clk;

  flash_poll_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WDOG_W(WW)) u0 (
    .clk(clk), .rst(rst), .start(start), .poll_addr(poll_addr),
    .max_pairs(max_pairs), .busy(busy), .done(done), .pass(pass),
    .result_data(result_data), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata)
  );

  function automatic logic [DW-1:0] flash_val(int k);
    logic [DW-1:0] v;
    if (k >= m_busy) return m_arr;
    v = 8'h08;
    v[6] = k[0];
    v[5] = (k >= m_err);
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0;
      lat_cnt <= 0;
    end else if (bus_req && !bus_ack) begin
      if (lat_cnt >= m_lat) begin
        bus_ack <= 1'b1;
        lat_cnt <= 0;
        if (bus_addr != m_addr) bad_addr <= bad_addr + 1;
        if (bus_we) begin
          wr_cnt  <= wr_cnt + 1;
          wr_last <= bus_wdata;
        end else begin
          bus_rdata <= flash_val(rd_cnt);
          rd_cnt    <= rd_cnt + 1;
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      bus_ack <= 1'b0;
    end
    if (!rst && done) done_cnt <= done_cnt + 1;
  end

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (busy=%0d err=%0d max=%0d)",
               req, act, exp, m_busy, m_err, max_pairs);
    end
  endtask

  task automatic run_one(int b, int e, int mx, logic [DW-1:0] arr, logic [AW-1:0] a);
    bit e_pass, conf, fin;
    int p, e_reads, e_res, waited;
    logic [DW-1:0] x, y;
    int lim;
    // reference outcome from the requirements
    lim = (mx == 0) ? 1 : mx;
    m_busy = b; m_err = e; m_arr = arr; m_addr = a; m_lat = (b + e) % 3;
    conf = 0; fin = 0; p = 0; e_pass = 0; e_res = 0;
    while (!fin) begin
      x = flash_val(2*p);
      y = flash_val(2*p + 1);
      if (x[6] == y[6]) begin
        e_pass = 1; e_res = flash_val(2*p + 2); fin = 1;
      end else if (p + 1 >= lim || conf) begin
        fin = 1;
      end else begin
        conf = y[5];
      end
      p++;
    end
    e_reads = 2*p + (e_pass ? 1 : 0);

    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; bad_addr = 0; done_cnt = 0; wr_last = '0;
    poll_addr = a; max_pairs = mx[WW-1:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 busy after start", busy, 1);
    // R9: second start while busy, different address
    poll_addr = ~a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 2000) begin
      if (!busy) check("R8 busy held", busy, 1);
      @(negedge clk);
      waited++;
    end
    check("R8 done seen", done, 1);
    check("R8 busy low with done", busy, 0);
    check(e_pass ? "R3 pass flag" : "R5 fail flag", pass, e_pass);
    check(e_pass ? "R3 result data" : "R6 result zero", result_data, e_res);
    check("R2 R4 R5 R7 read count", rd_cnt, e_reads);
    check("R6 write count", wr_cnt, e_pass ? 0 : 1);
    if (!e_pass) check("R6 write data", wr_last, 8'hF0);
    check("R2 R9 address", bad_addr, 0);
    @(negedge clk);
    check("R8 done one cycle", done, 0);
    repeat (3) @(negedge clk);
    check("R9 single done", done_cnt, 1);
  endtask

  initial begin
    #(4 * 190000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int mxs[4];
    mxs[0] = 0; mxs[1] = 1; mxs[2] = 3; mxs[3] = 8;
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 pass", pass, 0);
    check("R1 req", bus_req, 0);
    rst = 1'b0;
    for (int b = 0; b < 10; b++)
      for (int e = 0; e < 11; e++)
        for (int m = 0; m < 4; m++)
          for (int v = 0; v < 2; v++)
            run_one(b, e, mxs[m], (v == 0) ? 8'hA5 : 8'h3C, AW'(b + e + m));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule